// File: doc/BRIEF.md
# XOR-Tree Board Test Gatekeeper

This block decides when a chip may drive its XOR-tree output, which board testers use to prove interconnect continuity. It watches four asynchronous control levels: a power-good level, an active-low system reset, an active-low strap that selects other test modes, and an active-low request for XOR-tree mode. The output is enabled only after a legal order of events:

1. Power comes up.
2. The reset is held for a fixed number of cycles counted from power-good.
3. The reset is released.
4. The XOR request arrives, with no other test mode used in between.

Any break in that order puts the block into a lockout state. Only a fresh, complete reset clears it.

While the mode is active, the input pins are sampled into a register every cycle. They are then folded through a serial chain of XOR stages, one pin per stage, onto the single tree output. The pin vector and the tree output are static board levels rather than a stream of items, so they carry no valid/ready handshake. Back-pressure does not apply. All control and status pins are plain levels. Each control input crosses a two-flop synchronizer before the sequencer sees it.

Top module: `xt_ctrl`

## Requirements
- R1: While `arst_n` is low, and on the first cycle after it rises, `tree_o`, `xor_active_o`, `seq_err_o` and `lockout_o` are all 0.
- R2: The sequencer counts cycles from the point where it sees power-good high. If reset is released before RST_CYC (default 128) cycles have been counted, `lockout_o` goes to 1. This includes the case where reset is not asserted at all when power-good rises.
- R3: Reset may already be asserted before power-good rises. Holding reset longer than RST_CYC cycles is legal, because the counter saturates. Releasing reset after the count is complete leaves all status outputs at 0 (ready).
- R4: Asserting the test-mode strap (`tmode_n_i` = 0) while ready sets `lockout_o` to 1. A later XOR request then leaves `xor_active_o` at 0 until a full reset sequence has completed.
- R5: An XOR request (`xreq_n_i` = 0) while ready raises `xor_active_o` on the fifth rising edge after the request changes. This covers two synchronizer stages, one state update and WAKE_CYC = 2 wake cycles. `tree_o` stays 0 until then.
- R6: While `xor_active_o` is 1, `tree_o` equals the XOR of all PIN_W bits of `pins_i` as sampled on the previous rising edge. Flipping any single pin flips `tree_o`.
- R7: Deasserting the XOR request drops `xor_active_o` and sets `lockout_o`. Re-asserting the request is then ignored until a full reset.
- R8: Power-good going low in any state returns the block to idle within three rising edges. In idle, `xor_active_o`, `lockout_o` and `tree_o` are 0, and the reset count restarts.
- R9: `seq_err_o` is 1 one cycle after the synchronized XOR request is seen in the off, reset-hold or lockout state. Otherwise it is 0.
- R10: A full reset means asserting `sys_rst_n_i` low with power-good high for at least RST_CYC cycles and then releasing it. This is the only way out of lockout other than a power-good drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset of the block's flops |
| pwr_ok_i | input | 1 | Power-good level, active high, asynchronous |
| sys_rst_n_i | input | 1 | Monitored system reset, active low, asynchronous |
| tmode_n_i | input | 1 | Other-test-mode strap, active low, asynchronous |
| xreq_n_i | input | 1 | XOR-tree mode request, active low, asynchronous |
| pins_i | input | PIN_W | Board pins folded into the XOR chain |
| tree_o | output | 1 | XOR chain output, 0 unless active |
| xor_active_o | output | 1 | XOR-tree mode is live |
| seq_err_o | output | 1 | XOR request seen in an illegal state |
| lockout_o | output | 1 | Entry blocked until full reset |

## Verification
The bench covers the following corner cases. A premature reset release, including one where reset was never asserted at power-up, must lock the block. A design that counted from the reset edge, or never checked the count, would go ready instead. A strap use or a dropped request followed by a new request must stay locked. A design that re-armed from lockout would drive the tree output without a fresh reset. The two wake cycles are probed one edge early: a design that skipped them would show an active, non-zero output there. Single-pin flips around a fixed base pattern show that every stage of the chain is in the fold. A power-good drop during active mode must silence everything, even with a non-zero pin parity present.

// File: rtl/xt_pkg.sv
package xt_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_HOLD   = 3'd1,
    ST_READY  = 3'd2,
    ST_ARM    = 3'd3,
    ST_ACTIVE = 3'd4,
    ST_LOCK   = 3'd5
  } xt_state_e;
endpackage

// File: rtl/xt_sync.sv
module xt_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // two flops per bit, each bit with its own idle value
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        meta_q <= RST_VAL[i];
        stab_q <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        stab_q <= meta_q;
      end
    end
    assign q_o[i] = stab_q;
  end
endmodule

// File: rtl/xt_chain.sv
module xt_chain #(
  parameter int PIN_W = 8
) (
  input  logic [PIN_W-1:0] pin_i,
  output logic             fold_o
);
  logic [PIN_W-1:0] link;
  // serial chain: each stage adds exactly one pin
  for (genvar i = 0; i < PIN_W; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign link[i] = pin_i[i];
    end else begin : g_tail
      assign link[i] = link[i-1] ^ pin_i[i];
    end
  end
  assign fold_o = link[PIN_W-1];
endmodule

// File: rtl/xt_seq.sv
module xt_seq
  import xt_pkg::*;
#(
  parameter int RST_CYC  = 128,
  parameter int WAKE_CYC = 2
) (
  input  logic      clk,
  input  logic      arst_n,
  input  logic      pg_i,
  input  logic      rst_i,
  input  logic      tm_i,
  input  logic      xr_i,
  output xt_state_e st_o,
  output logic      cnt_done_o,
  output logic      err_o
);
  localparam int CW = $clog2(RST_CYC + 1);
  localparam int WW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;

  xt_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [WW-1:0] wk_q, wk_d;
  logic err_q;
  logic done;

  assign done = (cnt_q >= CW'(RST_CYC));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    wk_d  = wk_q;
    if (!pg_i) begin
      st_d  = ST_OFF;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          st_d  = ST_HOLD;
          cnt_d = '0;
        end
        ST_HOLD: begin
          if (rst_i) begin
            if (!done) cnt_d = cnt_q + CW'(1);
          end else begin
            st_d = done ? ST_READY : ST_LOCK;
          end
        end
        ST_READY: begin
          if (rst_i) begin
            st_d  = ST_HOLD;
            cnt_d = '0;
          end else if (tm_i) begin
            st_d = ST_LOCK;
          end else if (xr_i) begin
            st_d = ST_ARM;
            wk_d = '0;
          end
        end
        ST_ARM: begin
          if (rst_i) begin
            st_d  = ST_HOLD;
            cnt_d = '0;
          end else if (!xr_i) begin
            st_d = ST_LOCK;
          end else if (wk_q == WW'(WAKE_CYC - 1)) begin
            st_d = ST_ACTIVE;
          end else begin
            wk_d = wk_q + WW'(1);
          end
        end
        ST_ACTIVE: begin
          if (rst_i) begin
            st_d  = ST_HOLD;
            cnt_d = '0;
          end else if (!xr_i) begin
            st_d = ST_LOCK;
          end
        end
        ST_LOCK: begin
          if (rst_i) begin
            st_d  = ST_HOLD;
            cnt_d = '0;
          end
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
      wk_q  <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      wk_q  <= wk_d;
      err_q <= xr_i && (st_q == ST_OFF || st_q == ST_HOLD || st_q == ST_LOCK);
    end
  end

  assign st_o       = st_q;
  assign cnt_done_o = done;
  assign err_o      = err_q;
endmodule

// File: rtl/xt_ctrl.sv
module xt_ctrl
  import xt_pkg::*;
#(
  parameter int PIN_W    = 8,
  parameter int RST_CYC  = 128,
  parameter int WAKE_CYC = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             pwr_ok_i,
  input  logic             sys_rst_n_i,
  input  logic             tmode_n_i,
  input  logic             xreq_n_i,
  input  logic [PIN_W-1:0] pins_i,
  output logic             tree_o,
  output logic             xor_active_o,
  output logic             seq_err_o,
  output logic             lockout_o
);
  // idle values: power low, reset asserted, strap and request released
  logic [3:0] ctl_raw, ctl_s;
  logic pg_s, rst_s, tm_s, xr_s;
  xt_state_e st_w;
  logic cnt_done_w;
  logic [PIN_W-1:0] pin_q;
  logic fold_w;

  assign ctl_raw = {xreq_n_i, tmode_n_i, sys_rst_n_i, pwr_ok_i};

  xt_sync #(.W(4), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .arst_n(arst_n), .d_i(ctl_raw), .q_o(ctl_s)
  );

  assign pg_s  = ctl_s[0];
  assign rst_s = ~ctl_s[1];
  assign tm_s  = ~ctl_s[2];
  assign xr_s  = ~ctl_s[3];

  xt_seq #(.RST_CYC(RST_CYC), .WAKE_CYC(WAKE_CYC)) u_seq (
    .clk(clk), .arst_n(arst_n), .pg_i(pg_s), .rst_i(rst_s), .tm_i(tm_s),
    .xr_i(xr_s), .st_o(st_w), .cnt_done_o(cnt_done_w), .err_o(seq_err_o)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pin_q <= '0;
    else         pin_q <= pins_i;
  end

  xt_chain #(.PIN_W(PIN_W)) u_chain (.pin_i(pin_q), .fold_o(fold_w));

  assign xor_active_o = (st_w == ST_ACTIVE);
  assign lockout_o    = (st_w == ST_LOCK);
  assign tree_o       = xor_active_o & fold_w;
endmodule

// File: rtl/xt_ctrl_chk.sv
module xt_ctrl_chk
  import xt_pkg::*;
#(
  parameter int PIN_W    = 8,
  parameter int WAKE_CYC = 2
) (
  input logic             clk,
  input logic             arst_n,
  input xt_state_e        st,
  input logic             pg_s,
  input logic             rst_s,
  input logic             tm_s,
  input logic             xr_s,
  input logic             cnt_done,
  input logic [PIN_W-1:0] pin_q,
  input logic             tree_o,
  input logic             act,
  input logic             err,
  input logic             lock
);
  logic [15:0] arm_run;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)            arm_run <= '0;
    else if (st == ST_ARM)  arm_run <= arm_run + 16'd1;
    else                    arm_run <= '0;
  end

  a_r2_ready_needs_count: assert property (@(posedge clk) disable iff (!arst_n)
    (st == ST_READY && $past(st) == ST_HOLD) |-> $past(cnt_done));
  a_r2_early_release_locks: assert property (@(posedge clk) disable iff (!arst_n)
    (st == ST_HOLD && pg_s && !rst_s && !cnt_done) |=> lock);
  a_r4_strap_locks: assert property (@(posedge clk) disable iff (!arst_n)
    (st == ST_READY && pg_s && !rst_s && tm_s) |=> lock);
  a_r5_wake_cycles: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(act) |-> (arm_run == 16'(WAKE_CYC) && $past(xr_s)));
  a_r5_tree_quiet: assert property (@(posedge clk) disable iff (!arst_n)
    !act |-> !tree_o);
  a_r6_parity: assert property (@(posedge clk) disable iff (!arst_n)
    act |-> (tree_o == ^pin_q));
  a_r7_drop_locks: assert property (@(posedge clk) disable iff (!arst_n)
    (act && pg_s && !rst_s && !xr_s) |=> lock);
  a_r10_lock_exit: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(lock) |-> (st == ST_HOLD || st == ST_OFF));
  a_r8_pg_idle: assert property (@(posedge clk) disable iff (!arst_n)
    !pg_s |=> (st == ST_OFF && !act && !lock));
  a_r9_err_set: assert property (@(posedge clk) disable iff (!arst_n)
    (xr_s && (st == ST_OFF || st == ST_HOLD || st == ST_LOCK)) |=> err);
  a_r9_err_clear: assert property (@(posedge clk) disable iff (!arst_n)
    !xr_s |=> !err);
endmodule

bind xt_ctrl xt_ctrl_chk #(.PIN_W(PIN_W), .WAKE_CYC(WAKE_CYC)) u_chk (
  .clk(clk), .arst_n(arst_n), .st(st_w), .pg_s(pg_s), .rst_s(rst_s),
  .tm_s(tm_s), .xr_s(xr_s), .cnt_done(cnt_done_w), .pin_q(pin_q),
  .tree_o(tree_o), .act(xor_active_o), .err(seq_err_o), .lock(lockout_o)
);

// File: tb/sim_xt_ctrl.sv
`timescale 1ns/1ps
module sim_xt_ctrl;
  localparam int PW = 8;
  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic pg = 1'b0, rst_n = 1'b0, tm_n = 1'b1, xr_n = 1'b1;
  logic [PW-1:0] pins = '0;
  logic tree, act, err, lock;
  int n_cmp = 0, n_bad = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  xt_ctrl #(.PIN_W(PW)) u0 (
    .clk(clk), .arst_n(arst_n), .pwr_ok_i(pg), .sys_rst_n_i(rst_n),
    .tmode_n_i(tm_n), .xreq_n_i(xr_n), .pins_i(pins), .tree_o(tree),
    .xor_active_o(act), .seq_err_o(err), .lockout_o(lock)
  );

  typedef struct { logic [3:0] v; string tag; } exp_t;
  exp_t sb[$];

  // driver side: queue an expectation {active, err, lockout, tree}
  task automatic expect_out(input logic [3:0] v, input string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares queued items 2 ns after each falling edge
  always begin
    @(negedge clk);
    #2;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if ({act, err, lock, tree} !== e.v) begin
        n_bad++;
        $display("FAIL %s: got act/err/lock/tree=%b expected %b",
                 e.tag, {act, err, lock, tree}, e.v);
      end
    end
  end

  task automatic full_reset();
    rst_n = 1'b0; step(140);
    rst_n = 1'b1; step(5);
  endtask

  initial begin
    step(3);
    expect_out(4'b0000, "R1 during reset");
    step(1);
    arst_n = 1'b1;
    step(1);
    expect_out(4'b0000, "R1 after reset");

    // R9: request while off
    xr_n = 1'b0; step(4);
    expect_out(4'b0100, "R9 request while off");
    xr_n = 1'b1; step(4);
    expect_out(4'b0000, "R9 cleared");

    // R2: reset held from before power-good but released too early
    pg = 1'b1; step(50);
    rst_n = 1'b1; step(5);
    expect_out(4'b0010, "R2 early release locks");
    xr_n = 1'b0; step(8);
    expect_out(4'b0110, "R7 request ignored in lockout");
    xr_n = 1'b1; step(4);

    // R3/R10: long reset, counter saturates, ready
    rst_n = 1'b0; step(200);
    rst_n = 1'b1; step(5);
    expect_out(4'b0000, "R3 long hold then ready");

    // R5: wake timing
    pins = 8'h07;
    xr_n = 1'b0; step(4);
    expect_out(4'b0000, "R5 still waking");
    step(1);
    expect_out(4'b1001, "R5 active on fifth edge");

    // R6: parity patterns
    begin
      logic [PW-1:0] pats [4];
      pats = '{8'h00, 8'hFF, 8'h80, 8'h3C};
      for (int k = 0; k < 4; k++) begin
        pins = pats[k]; step(1);
        expect_out({3'b100, ^pats[k]}, "R6 pattern");
      end
      for (int b = 0; b < PW; b++) begin
        logic [PW-1:0] p;
        p = 8'h5A ^ (8'h01 << b);
        pins = p; step(1);
        expect_out({3'b100, ^p}, "R6 single pin flip");
      end
    end

    // R7: drop request
    xr_n = 1'b1; step(4);
    expect_out(4'b0010, "R7 drop locks");
    xr_n = 1'b0; step(8);
    expect_out(4'b0110, "R7 re-request ignored");
    xr_n = 1'b1; step(4);

    // R4: strap use blocks XOR entry
    full_reset();
    expect_out(4'b0000, "R10 full reset clears lockout");
    tm_n = 1'b0; step(5);
    expect_out(4'b0010, "R4 strap locks");
    tm_n = 1'b1;
    xr_n = 1'b0; step(8);
    expect_out(4'b0110, "R4 request ignored after strap");
    xr_n = 1'b1; step(5);

    // R8: power-good drop while active
    full_reset();
    pins = 8'h01;
    xr_n = 1'b0; step(6);
    expect_out(4'b1001, "R8 precondition active");
    pg = 1'b0; xr_n = 1'b1; step(4);
    expect_out(4'b0000, "R8 power drop idles");

    // R2: power-good rises with reset not asserted
    pg = 1'b1; step(5);
    expect_out(4'b0010, "R2 no reset at power-up locks");

    step(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8ns * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule